// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block turns interrupt events raised by on-chip sources into four-word vectors and stores them in a circular buffer in memory through a simple word-write port. Events enter through a valid/ready input, wait in a small queue, and are written out one word per cycle. The block owns the write pointer. Host software owns the read pointer, which it updates by a register write or by a doorbell write. An interrupt line stays high while unread vectors remain in the ring.

Both pointers count bytes. Each vector takes 16 bytes, so the write pointer moves by 16 after the fourth word. When the next vector would land on the slot the host is still reading, the vector is dropped. A sticky overflow flag then appears in bit 31 of the write-pointer register, and the host clears it with a write-one control bit. If writeback is enabled, each change of the write-pointer word is also written to a separate memory address, so the host can poll memory instead of the register.

Register map (`reg_addr`):
- 0 control: bit0 ring enable, bit1 interrupt enable, bit2 writeback enable, bit3 overflow clear (write 1, reads 0), bits[8:4] log2 of ring size in 32-bit words.
- 1 ring base: address bits [39:8].
- 2 writeback address bits [31:2].
- 3 writeback address bits [39:32] in [7:0].
- 4 read pointer.
- 5 write pointer, with the overflow flag in bit 31.
- 6 doorbell: bit31 enable, low bits the doorbell index.
- 7 status: bit0 busy.

Top module: `ivr_producer`

## Requirements
- R1: With the ring enabled and room available, each accepted event produces four memory writes in consecutive cycles. The words go out in order 0 to 3, at byte addresses base + write pointer + 4*k, where base is {ring base register, 8'h00}.
- R2: The vector layout is as follows. Word 0 has the source ID in [7:0] and zeros above. Word 1 has the 28-bit source data in [27:0] and zeros above. Word 2 has the ring ID in [7:0], the VM ID in [15:8] and the address-space ID in [31:16]. Word 3 is zero.
- R3: After word 3 the write pointer advances by 16 and wraps modulo the ring size in bytes, which is 4 << L. L is control bits [8:4], clamped to the range 3..MAX_LOG2.
- R4: If (write pointer + 16) mod ring size equals the read pointer, the event is dropped. No vector word is written, the write pointer is unchanged, and bit 31 of the write-pointer register becomes 1.
- R5: The overflow flag stays set until a control write with bit3 = 1. Control bit3 always reads back 0.
- R6: While ring enable (control bit0) is 0, events are accepted and discarded. No memory write occurs and the write pointer is unchanged.
- R7: irq_out is high exactly when ring enable and interrupt enable (control bit1) are both 1 and the read pointer differs from the write pointer.
- R8: With writeback enabled (control bit2), one extra word is written after each vector and after each overflow drop. It goes to {wb high[7:0], wb low[31:2], 2'b00}, and its data equals the write-pointer register value.
- R9: The read pointer is loaded by a register write at offset 4, or by a doorbell write when doorbell bit31 is 1 and db_offset equals the doorbell index; the doorbell wins if both happen in one cycle. The value is masked to the ring size and aligned down to 16 bytes. A doorbell with a mismatched offset or with the doorbell disabled has no effect.
- R10: The ring base register (offset 1) reads back as written, and it sets address bits [39:8] of every vector word.
- R11: Status bit0 (offset 7) is 1 while an event is queued or a vector or writeback is in progress, and 0 otherwise.
- R12: After reset, all registers read 0, irq_out is 0, ev_ready is 1 and no memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event queue has room |
| ev_src_id | input | 8 | Source ID |
| ev_src_data | input | 28 | Source data |
| ev_ring_id | input | 8 | Ring ID |
| ev_vmid | input | 8 | VM ID |
| ev_pasid | input | 16 | Process address-space ID |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| db_we | input | 1 | Doorbell write strobe |
| db_offset | input | DB_W | Doorbell offset |
| db_data | input | 32 | Doorbell data (new read pointer) |
| mem_we | output | 1 | Memory word write |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| irq_out | output | 1 | Interrupt request |

## Verification
The main path is tried with three patterns: single events with idle gaps, a back-to-back burst that queues in the input FIFO, and a fill up to the read pointer. The single events check word order, layout and address stepping. The burst shows that queued events keep their order and that writebacks interleave correctly. The fill separates an accepted vector from a dropped one at the exact slot before the read pointer. The pointer wrap, the doorbell index match and mismatch, and the disabled ring are each tried on their own, so that a pointer that fails to wrap cannot be mistaken for a vector that was dropped.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

   typedef struct packed {
      logic [15:0] pasid;
      logic [7:0]  vmid;
      logic [7:0]  ring_id;
      logic [27:0] data;
      logic [7:0]  src;
   } ivr_evt_t;

   localparam int EVT_W = $bits(ivr_evt_t);

   typedef enum logic [1:0] {WS_IDLE, WS_WORD, WS_WB} ivr_wstate_e;

   localparam logic [2:0] OFS_CTRL   = 3'd0;
   localparam logic [2:0] OFS_BASE   = 3'd1;
   localparam logic [2:0] OFS_WBLO   = 3'd2;
   localparam logic [2:0] OFS_WBHI   = 3'd3;
   localparam logic [2:0] OFS_RPTR   = 3'd4;
   localparam logic [2:0] OFS_WPTR   = 3'd5;
   localparam logic [2:0] OFS_DBELL  = 3'd6;
   localparam logic [2:0] OFS_STATUS = 3'd7;

   localparam int CB_RING_EN  = 0;
   localparam int CB_IRQ_EN   = 1;
   localparam int CB_WB_EN    = 2;
   localparam int CB_OVF_CLR  = 3;
   localparam int CB_SIZE_LSB = 4;
   localparam int CB_SIZE_W   = 5;
   localparam int MIN_LOG2    = 3;

   function automatic logic [31:0] vec_word(input ivr_evt_t e, input logic [1:0] k);
      logic [31:0] w;
      case (k)
         2'd0:    w = {24'h0, e.src};
         2'd1:    w = {4'h0, e.data};
         2'd2:    w = {e.pasid, e.vmid, e.ring_id};
         default: w = 32'h0;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/ivr_evt_fifo.sv
module ivr_evt_fifo #(
   parameter int W     = 68,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("ivr_evt_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic         held;
      logic [W-1:0] slot;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held <= 1'b0;
            slot <= '0;
         end else begin
            if (push && !held) begin
               held <= 1'b1;
               slot <= din;
            end else if (pop && held) begin
               held <= 1'b0;
            end
         end
      end
      assign full  = held;
      assign empty = !held;
      assign dout  = slot;
   end else begin : g_ring
      localparam int AW = $clog2(DEPTH);
      localparam int CW = AW + 1;
      logic [W-1:0]  mem [DEPTH];
      logic [AW-1:0] wr_i, rd_i;
      logic [CW-1:0] cnt;
      logic          do_push, do_pop;

      assign full    = (cnt == CW'(DEPTH));
      assign empty   = (cnt == '0);
      assign do_push = push && !full;
      assign do_pop  = pop && !empty;
      assign dout    = mem[rd_i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_i <= '0;
            rd_i <= '0;
            cnt  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else begin
            if (do_push) begin
               mem[wr_i] <= din;
               wr_i      <= (wr_i == AW'(DEPTH - 1)) ? '0 : wr_i + 1'b1;
            end
            if (do_pop)
               rd_i <= (rd_i == AW'(DEPTH - 1)) ? '0 : rd_i + 1'b1;
            case ({do_push, do_pop})
               2'b10:   cnt <= cnt + 1'b1;
               2'b01:   cnt <= cnt - 1'b1;
               default: cnt <= cnt;
            endcase
         end
      end
   end

endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
   import ivr_pkg::*;
#(
   parameter int PW       = 16,
   parameter int MAX_LOG2 = 14,
   parameter int DB_W     = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [2:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic            db_we,
   input  logic [DB_W-1:0] db_offset,
   input  logic [31:0]     db_data,
   input  logic            commit,
   input  logic            drop,
   input  logic            busy,
   output logic            ring_en,
   output logic            irq_en,
   output logic            wb_en,
   output logic [39:0]     base40,
   output logic [39:0]     wb_addr,
   output logic [PW-1:0]   wptr,
   output logic [PW-1:0]   rptr,
   output logic            ovf,
   output logic [PW-1:0]   ptr_mask,
   output logic            ovf_clr,
   output logic            wptr_wr
);

   logic [CB_SIZE_W-1:0] size_f, lg_eff;
   logic [31:0]          base_r;
   logic [29:0]          wb_lo;
   logic [7:0]           wb_hi;
   logic                 db_en;
   logic [DB_W-1:0]      db_idx;
   logic [PW-1:0]        align_m;
   logic                 db_hit, rptr_wr, ctrl_wr;
   logic                 unused_hi;

   assign unused_hi = ^{db_data[31:PW], reg_wdata[31:PW]};

   always_comb begin
      if (size_f < CB_SIZE_W'(MIN_LOG2))       lg_eff = CB_SIZE_W'(MIN_LOG2);
      else if (size_f > CB_SIZE_W'(MAX_LOG2))  lg_eff = CB_SIZE_W'(MAX_LOG2);
      else                                     lg_eff = size_f;
      for (int b = 0; b < PW; b++) ptr_mask[b] = (b < int'(lg_eff) + 2);
   end

   assign align_m = ptr_mask & ~PW'(15);
   assign ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
   assign ovf_clr = ctrl_wr && reg_wdata[CB_OVF_CLR];
   assign wptr_wr = reg_we && (reg_addr == OFS_WPTR);
   assign rptr_wr = reg_we && (reg_addr == OFS_RPTR);
   assign db_hit  = db_we && db_en && (db_offset == db_idx);
   assign base40  = {base_r, 8'h00};
   assign wb_addr = {wb_hi, wb_lo, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_en <= 1'b0;
         irq_en  <= 1'b0;
         wb_en   <= 1'b0;
         size_f  <= '0;
         base_r  <= '0;
         wb_lo   <= '0;
         wb_hi   <= '0;
         db_en   <= 1'b0;
         db_idx  <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            OFS_CTRL: begin
               ring_en <= reg_wdata[CB_RING_EN];
               irq_en  <= reg_wdata[CB_IRQ_EN];
               wb_en   <= reg_wdata[CB_WB_EN];
               size_f  <= reg_wdata[CB_SIZE_LSB +: CB_SIZE_W];
            end
            OFS_BASE:  base_r <= reg_wdata;
            OFS_WBLO:  wb_lo  <= reg_wdata[31:2];
            OFS_WBHI:  wb_hi  <= reg_wdata[7:0];
            OFS_DBELL: begin
               db_en  <= reg_wdata[31];
               db_idx <= reg_wdata[DB_W-1:0];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         ovf  <= 1'b0;
      end else begin
         if (wptr_wr)     wptr <= reg_wdata[PW-1:0] & align_m;
         else if (commit) wptr <= (wptr + PW'(16)) & ptr_mask;

         if (db_hit)       rptr <= db_data[PW-1:0] & align_m;
         else if (rptr_wr) rptr <= reg_wdata[PW-1:0] & align_m;

         if (drop)         ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_CTRL:   reg_rdata = {23'h0, size_f, 1'b0, wb_en, irq_en, ring_en};
         OFS_BASE:   reg_rdata = base_r;
         OFS_WBLO:   reg_rdata = {wb_lo, 2'b00};
         OFS_WBHI:   reg_rdata = {24'h0, wb_hi};
         OFS_RPTR:   reg_rdata = 32'(rptr);
         OFS_WPTR:   reg_rdata = {ovf, 31'(wptr)};
         OFS_DBELL:  reg_rdata = {db_en, 31'(db_idx)};
         default:    reg_rdata = {31'h0, busy};
      endcase
   end

endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
   import ivr_pkg::*;
#(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_valid,
   input  ivr_evt_t      evt,
   input  logic          ring_en,
   input  logic          wb_en,
   input  logic [39:0]   base40,
   input  logic [39:0]   wb_addr,
   input  logic [PW-1:0] wptr,
   input  logic [PW-1:0] rptr,
   input  logic [PW-1:0] ptr_mask,
   input  logic          ovf,
   output logic          pop,
   output logic          commit,
   output logic          drop,
   output logic          mem_we,
   output logic [39:0]   mem_addr,
   output logic [31:0]   mem_wdata,
   output logic          active,
   output logic          in_word,
   output logic          in_wb,
   output logic [1:0]    word_idx
);

   ivr_wstate_e state;
   ivr_evt_t    cur;
   logic        ring_full, start;

   assign ring_full = (((wptr + PW'(16)) & ptr_mask) == rptr);
   assign pop       = (state == WS_IDLE) && evt_valid;
   assign start     = pop && ring_en && !ring_full;
   assign drop      = pop && ring_en && ring_full;
   assign in_word   = (state == WS_WORD);
   assign in_wb     = (state == WS_WB);
   assign commit    = in_word && (word_idx == 2'd3);
   assign active    = (state != WS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= WS_IDLE;
         cur      <= '0;
         word_idx <= '0;
      end else begin
         case (state)
            WS_IDLE: begin
               if (start) begin
                  cur      <= evt;
                  word_idx <= '0;
                  state    <= WS_WORD;
               end else if (drop && wb_en) begin
                  state <= WS_WB;
               end
            end
            WS_WORD: begin
               word_idx <= word_idx + 1'b1;
               if (word_idx == 2'd3) state <= wb_en ? WS_WB : WS_IDLE;
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we    = in_word || in_wb;
      mem_addr  = '0;
      mem_wdata = '0;
      if (in_word) begin
         mem_addr  = base40 + 40'(wptr) + 40'({word_idx, 2'b00});
         mem_wdata = vec_word(cur, word_idx);
      end else if (in_wb) begin
         mem_addr  = wb_addr;
         mem_wdata = {ovf, 31'(wptr)};
      end
   end

endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
   import ivr_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter int MAX_LOG2   = 14,
   parameter int DB_W       = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ev_valid,
   output logic            ev_ready,
   input  logic [7:0]      ev_src_id,
   input  logic [27:0]     ev_src_data,
   input  logic [7:0]      ev_ring_id,
   input  logic [7:0]      ev_vmid,
   input  logic [15:0]     ev_pasid,
   input  logic            reg_we,
   input  logic [2:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic            db_we,
   input  logic [DB_W-1:0] db_offset,
   input  logic [31:0]     db_data,
   output logic            mem_we,
   output logic [39:0]     mem_addr,
   output logic [31:0]     mem_wdata,
   output logic            irq_out
);

   localparam int PW = MAX_LOG2 + 2;

   if (MAX_LOG2 < MIN_LOG2 || MAX_LOG2 > 28) begin : g_bad_log2
      $error("ivr_producer: MAX_LOG2 out of range 3..28");
   end
   if (DB_W < 1 || DB_W > 31) begin : g_bad_dbw
      $error("ivr_producer: DB_W out of range 1..31");
   end

   ivr_evt_t      ev_in, ev_head;
   logic          q_full, q_empty, pop;
   logic          ring_en, irq_en, wb_en, ovf, ovf_clr, wptr_wr;
   logic [39:0]   base40, wb_addr;
   logic [PW-1:0] wptr, rptr, ptr_mask;
   logic          commit, drop, active, in_word, in_wb;
   logic [1:0]    word_idx;

   assign ev_in    = '{pasid: ev_pasid, vmid: ev_vmid, ring_id: ev_ring_id,
                       data: ev_src_data, src: ev_src_id};
   assign ev_ready = !q_full;
   assign irq_out  = ring_en && irq_en && (rptr != wptr);

   ivr_evt_fifo #(.W(EVT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (ev_valid),
      .din   (ev_in),
      .full  (q_full),
      .pop   (pop),
      .dout  (ev_head),
      .empty (q_empty)
   );

   ivr_regs #(.PW(PW), .MAX_LOG2(MAX_LOG2), .DB_W(DB_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .db_we     (db_we),
      .db_offset (db_offset),
      .db_data   (db_data),
      .commit    (commit),
      .drop      (drop),
      .busy      (active || !q_empty),
      .ring_en   (ring_en),
      .irq_en    (irq_en),
      .wb_en     (wb_en),
      .base40    (base40),
      .wb_addr   (wb_addr),
      .wptr      (wptr),
      .rptr      (rptr),
      .ovf       (ovf),
      .ptr_mask  (ptr_mask),
      .ovf_clr   (ovf_clr),
      .wptr_wr   (wptr_wr)
   );

   ivr_writer #(.PW(PW)) u_writer (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_valid (!q_empty),
      .evt       (ev_head),
      .ring_en   (ring_en),
      .wb_en     (wb_en),
      .base40    (base40),
      .wb_addr   (wb_addr),
      .wptr      (wptr),
      .rptr      (rptr),
      .ptr_mask  (ptr_mask),
      .ovf       (ovf),
      .pop       (pop),
      .commit    (commit),
      .drop      (drop),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .active    (active),
      .in_word   (in_word),
      .in_wb     (in_wb),
      .word_idx  (word_idx)
   );

endmodule

// File: rtl/ivr_producer_chk.sv
module ivr_producer_chk #(
   parameter int PW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_we,
   input logic [39:0]   mem_addr,
   input logic          in_word,
   input logic          in_wb,
   input logic [1:0]    word_idx,
   input logic          commit,
   input logic          drop,
   input logic [PW-1:0] wptr,
   input logic [PW-1:0] ptr_mask,
   input logic          wptr_wr,
   input logic          ovf,
   input logic          ovf_clr,
   input logic          ring_en,
   input logic          irq_en,
   input logic          wb_en,
   input logic          irq_out
);

   // R1: successive words of one vector step the address by 4
   p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_word && word_idx != 2'd0) |-> (mem_we && mem_addr == $past(mem_addr) + 40'd4));

   // R3: pointer moves by 16 modulo the ring after the last word
   p_wptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !wptr_wr) |=> (wptr == (($past(wptr) + PW'(16)) & $past(ptr_mask))));

   // R4: a dropped vector leaves the pointer and sets the flag
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !wptr_wr) |=> (ovf && wptr == $past(wptr)));

   // R5: overflow flag is sticky until cleared
   p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);

   // R7: interrupt gated by both enables
   p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ring_en || !irq_en) |-> !irq_out);

   // R8: writeback follows a committed vector
   p_wb_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && wb_en) |=> (in_wb && mem_we));

endmodule

bind ivr_producer ivr_producer_chk #(.PW(PW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .in_word  (in_word),
   .in_wb    (in_wb),
   .word_idx (word_idx),
   .commit   (commit),
   .drop     (drop),
   .wptr     (wptr),
   .ptr_mask (ptr_mask),
   .wptr_wr  (wptr_wr),
   .ovf      (ovf),
   .ovf_clr  (ovf_clr),
   .ring_en  (ring_en),
   .irq_en   (irq_en),
   .wb_en    (wb_en),
   .irq_out  (irq_out)
);

// File: tb/ivr_producer_tb.sv
`timescale 1ns/100ps
module ivr_producer_tb;

   localparam int DB_W = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ev_valid = 1'b0;
   logic            ev_ready;
   logic [7:0]      ev_src_id = '0;
   logic [27:0]     ev_src_data = '0;
   logic [7:0]      ev_ring_id = '0;
   logic [7:0]      ev_vmid = '0;
   logic [15:0]     ev_pasid = '0;
   logic            reg_we = 1'b0;
   logic [2:0]      reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic            db_we = 1'b0;
   logic [DB_W-1:0] db_offset = '0;
   logic [31:0]     db_data = '0;
   logic            mem_we;
   logic [39:0]     mem_addr;
   logic [31:0]     mem_wdata;
   logic            irq_out;

   always #2.5 clk = ~clk;

   ivr_producer #(.FIFO_DEPTH(4), .MAX_LOG2(14), .DB_W(DB_W)) u_dut (.*);

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [39:0] q_addr[$];
   logic [31:0] q_data[$];
   string       q_tag[$];

   // model state
   int unsigned m_wptr = 0, m_rptr = 0, m_size = 64;
   bit          m_en = 0, m_wb = 0, m_ovf = 0;
   logic [39:0] m_base = '0, m_wbaddr = '0;

   task automatic fail_line(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
   endtask

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) fail_line(tag, what, act, exp);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         n_chk++;
         if (q_addr.size() == 0) begin
            fail_line("R6", "unexpected mem write addr", 64'(mem_addr), 64'hx);
         end else begin
            logic [39:0] ea;
            logic [31:0] ed;
            string       et;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            et = q_tag.pop_front();
            if (mem_addr !== ea) fail_line(et, "mem_addr", 64'(mem_addr), 64'(ea));
            else if (mem_wdata !== ed) fail_line(et, "mem_wdata", 64'(mem_wdata), 64'(ed));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic expect_wr(input logic [39:0] a, input logic [31:0] d, input string tag);
      q_addr.push_back(a);
      q_data.push_back(d);
      q_tag.push_back(tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, $sformatf("reg %0d", a), 64'(reg_rdata), 64'(exp));
   endtask

   task automatic set_ctrl(input bit en, input bit ie, input bit wb, input bit clr, input int lg);
      wr(3'd0, {23'h0, 5'(lg), clr, wb, ie, en});
      m_en = en; m_wb = wb;
      if (clr) m_ovf = 0;
      m_size = 4 << lg;
   endtask

   task automatic set_rptr(input int unsigned v);
      wr(3'd4, v);
      m_rptr = v & (m_size - 1) & ~32'd15;
   endtask

   task automatic doorbell(input logic [DB_W-1:0] off, input logic [31:0] d);
      @(negedge clk);
      db_we = 1'b1; db_offset = off; db_data = d;
      @(negedge clk);
      db_we = 1'b0;
   endtask

   task automatic push_wb();
      if (m_wb) expect_wr(m_wbaddr, {m_ovf, 31'(m_wptr)}, "R8");
   endtask

   // driver: predicts the result then presents the event
   task automatic send_evt(input logic [7:0] s, input logic [27:0] d, input logic [7:0] rg,
                           input logic [7:0] vm, input logic [15:0] pa);
      if (m_en) begin
         if (((m_wptr + 16) % m_size) == m_rptr) begin
            m_ovf = 1;
            push_wb();
         end else begin
            logic [39:0] a;
            a = m_base + 40'(m_wptr);
            expect_wr(a,          {24'h0, s},      "R1");
            expect_wr(a + 40'd4,  {4'h0, d},       "R2");
            expect_wr(a + 40'd8,  {pa, vm, rg},    "R2");
            expect_wr(a + 40'd12, 32'h0,           "R2");
            m_wptr = (m_wptr + 16) % m_size;
            push_wb();
         end
      end
      @(negedge clk);
      while (!ev_ready) @(negedge clk);
      ev_valid = 1'b1; ev_src_id = s; ev_src_data = d; ev_ring_id = rg; ev_vmid = vm; ev_pasid = pa;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (30) @(negedge clk);
      chk("R1", "scoreboard drained", 64'(q_addr.size()), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      rd(3'd0, 32'h0, "R12");
      rd(3'd5, 32'h0, "R12");
      rd(3'd7, 32'h0, "R12");
      chk("R12", "irq_out", 64'(irq_out), 64'd0);
      chk("R12", "ev_ready", 64'(ev_ready), 64'd1);

      // R10 base register
      wr(3'd1, 32'h0012_3456);
      m_base = 40'h12_3456_00;
      rd(3'd1, 32'h0012_3456, "R10");
      set_ctrl(1, 1, 0, 0, 4);   // 64-byte ring

      // R1 R2 single event
      send_evt(8'hA5, 28'hABC_DEF1, 8'h11, 8'h22, 16'h3344);
      settle();
      rd(3'd5, 32'h10, "R3");
      chk("R7", "irq pending", 64'(irq_out), 64'd1);

      send_evt(8'h01, 28'h000_0001, 8'h02, 8'h03, 16'h0004);
      settle();
      send_evt(8'hFF, 28'hFFF_FFFF, 8'hFF, 8'hFF, 16'hFFFF);
      settle();
      rd(3'd5, 32'h30, "R3");

      // R4 fill to the read pointer
      send_evt(8'h5A, 28'h123_4567, 8'h00, 8'h00, 16'h0000);
      settle();
      rd(3'd5, 32'h8000_0030, "R4");
      rd(3'd5, 32'h8000_0030, "R5");
      set_ctrl(1, 1, 0, 1, 4);
      rd(3'd5, 32'h30, "R5");
      rd(3'd0, 32'h0000_0043, "R5");

      // R9 register read pointer, R7 idle ring
      set_rptr(32'h37);
      rd(3'd4, 32'h30, "R9");
      chk("R7", "irq idle", 64'(irq_out), 64'd0);

      // R3 wrap
      send_evt(8'h3C, 28'h0F0_F0F0, 8'h7, 8'h8, 16'h9ABC);
      settle();
      rd(3'd5, 32'h0, "R3");
      chk("R7", "irq after wrap", 64'(irq_out), 64'd1);

      // R9 doorbell
      wr(3'd6, 32'h8000_0005);
      doorbell(10'd4, 32'h0);
      rd(3'd4, 32'h30, "R9");
      doorbell(10'd5, 32'h0);
      m_rptr = 0;
      rd(3'd4, 32'h0, "R9");
      chk("R7", "irq after doorbell", 64'(irq_out), 64'd0);
      wr(3'd6, 32'h0000_0005);
      doorbell(10'd5, 32'h10);
      rd(3'd4, 32'h0, "R9");

      // R7 interrupt enable gating
      send_evt(8'h44, 28'h555_5555, 8'h66, 8'h77, 16'h8888);
      settle();
      chk("R7", "irq with enable", 64'(irq_out), 64'd1);
      set_ctrl(1, 0, 0, 0, 4);
      @(negedge clk);
      chk("R7", "irq gated", 64'(irq_out), 64'd0);

      // R6 ring disabled
      set_ctrl(0, 1, 0, 0, 4);
      send_evt(8'h99, 28'h999_9999, 8'h99, 8'h99, 16'h9999);
      settle();
      rd(3'd5, 32'h10, "R6");
      rd(3'd7, 32'h0, "R11");

      // R8 writeback
      wr(3'd2, 32'h0000_8000);
      wr(3'd3, 32'h0000_003A);
      m_wbaddr = 40'h3A_0000_8000;
      set_ctrl(1, 1, 1, 0, 4);
      send_evt(8'h10, 28'h100_0010, 8'h1, 8'h2, 16'h1234);
      settle();
      send_evt(8'h20, 28'h200_0020, 8'h3, 8'h4, 16'h5678);
      settle();
      send_evt(8'h30, 28'h300_0030, 8'h5, 8'h6, 16'h9ABC);
      settle();
      rd(3'd5, 32'h8000_0030, "R4");

      // R11 busy while a vector is in flight
      set_ctrl(1, 1, 1, 1, 4);
      set_rptr(32'h30);
      send_evt(8'h40, 28'h400_0040, 8'h7, 8'h8, 16'hDEF0);
      rd(3'd7, 32'h1, "R11");
      settle();
      rd(3'd7, 32'h0, "R11");

      // burst through the input queue, ending on a drop
      send_evt(8'h51, 28'h511_1111, 8'h1, 8'h1, 16'h1111);
      send_evt(8'h52, 28'h522_2222, 8'h2, 8'h2, 16'h2222);
      send_evt(8'h53, 28'h533_3333, 8'h3, 8'h3, 16'h3333);
      settle();
      rd(3'd5, 32'h8000_0020, "R4");
      chk("R7", "irq final", 64'(irq_out), 64'd1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule